// File: doc/BRIEF.md
# Reference Clock Activity Monitor

This block watches two reference clock lines that arrive from a chassis backplane. Each line is treated as slow, asynchronous data. It is brought into the system clock domain and checked for edges over fixed windows of system-clock cycles. A line with at least one edge inside a window counts as toggling. A line with no edge counts as static. Whenever a line moves between those two states, the block latches an event flag for that line.

When both lines stay quiet for a whole window, the block raises a timeout flag and increments a 4-bit timeout tally. The tally saturates at its maximum value. It is cleared only when software clears the timeout flag.

Software sees all of this through one 8-bit status register and one 8-bit enable register on a plain synchronous register port. The event flags are cleared by writing ones to them. A registered, active-low level interrupt stays asserted while any enabled flag is set.

Top module: `refclk_activity_mon`

## Requirements
- R1: After reset the status register (offset 0x22) reads 0x00, the enable register (offset 0x23) reads 0x00 and `irq_n` is 1.
- R2: Status bit 0 becomes 1 when line 0 changes from static to toggling, and again when it changes from toggling to static.
- R3: Status bit 1 behaves like bit 0 but for line 1. A change on line 0 never sets bit 1.
- R4: A line counts as toggling when it shows an edge in every window of `WINDOW` system cycles. A line that keeps toggling at that rate raises no further event after its first one.
- R5: When neither line shows an edge for `WINDOW` consecutive cycles, status bit 2 becomes 1 and the tally in bits 7:4 goes up by one. This repeats for each further quiet window. No timeout happens while either line toggles.
- R6: The tally in bits 7:4 stops at 15 and does not wrap.
- R7: Writing a 1 to bit 0, 1 or 2 of the status register clears that bit. Writing a 0 to one of these bits leaves it unchanged.
- R8: Writing a 1 to status bit 2 also returns the tally in bits 7:4 to 0.
- R9: Status bit 3 always reads 0, and writes to it are ignored.
- R10: If a hardware event and a clearing write hit the same flag in the same cycle, the flag stays set. On a timeout collision the tally restarts at 1, so right after any clear of bit 2 the tally equals bit 2.
- R11: Enable register bits 2:0 enable the interrupt for status bits 2:0, and bits 7:3 read 0. `irq_n` is 0 exactly when some enabled status bit was set on the previous cycle.
- R12: `reg_rdata` is registered. It shows the register addressed on the previous cycle, and any offset other than 0x22 or 0x23 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 2 | Monitored reference clock lines (asynchronous) |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The hardest case to reach is a clearing write to bit 2 that lands in the exact cycle a timeout fires. A timeout fires only deep inside quiet windows, so its phase cannot be seen at the ports.

The bench holds both lines static, so timeouts repeat every `WINDOW` cycles. It then issues clear-and-read pairs spaced exactly one cycle longer than a window, so successive clears walk across every phase of the timeout period. After each clear it requires the tally to equal the flag, and it also requires at least one collision to have been seen.

Random writes with a fixed seed check the enable readback and the cases where written zeros must have no effect.

// File: rtl/rcam_pkg.sv
package rcam_pkg;
  localparam int          NUM_REF     = 2;
  localparam int          DATA_W      = 8;
  localparam int          ADDR_W      = 8;
  localparam int          TALLY_W     = 4;
  localparam int          NUM_FLAGS   = NUM_REF + 1;
  localparam int          TMO_BIT     = NUM_REF;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h22;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h23;
  localparam logic [TALLY_W-1:0] TALLY_MAX  = '1;
endpackage

// File: rtl/rcam_sync.sv
module rcam_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcam_activity.sv
module rcam_activity #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  output logic edge_o,
  output logic active,
  output logic change
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] WLAST = CW'(WINDOW - 1);

  logic          prev;
  logic          seen;
  logic [CW-1:0] win_cnt;
  logic          verdict;

  assign edge_o  = line_s ^ prev;
  assign verdict = seen | edge_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      seen    <= 1'b0;
      win_cnt <= '0;
      active  <= 1'b0;
      change  <= 1'b0;
    end else begin
      prev <= line_s;
      if (win_cnt == WLAST) begin
        win_cnt <= '0;
        seen    <= 1'b0;
        active  <= verdict;
        change  <= (verdict != active);
      end else begin
        win_cnt <= win_cnt + 1'b1;
        seen    <= verdict;
        change  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rcam_idle_timer.sv
module rcam_idle_timer #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic any_edge,
  output logic fire
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] WLAST = CW'(WINDOW - 1);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet <= '0;
      fire  <= 1'b0;
    end else if (any_edge) begin
      quiet <= '0;
      fire  <= 1'b0;
    end else if (quiet == WLAST) begin
      quiet <= '0;
      fire  <= 1'b1;
    end else begin
      quiet <= quiet + 1'b1;
      fire  <= 1'b0;
    end
  end
endmodule

// File: rtl/rcam_regs.sv
module rcam_regs
  import rcam_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_REF-1:0]   chg,
  input  logic                 tmo,
  output logic [DATA_W-1:0]    rdata,
  output logic                 irq_n,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] en,
  output logic [TALLY_W-1:0]   tally
);
  logic                 hit_status;
  logic                 hit_enable;
  logic [NUM_FLAGS-1:0] w1c;
  logic [NUM_FLAGS-1:0] hw_set;
  logic [DATA_W-1:0]    status_view;
  logic [DATA_W-1:0]    enable_view;
  wire                  unused_wdata_hi = ^wdata[DATA_W-1:NUM_FLAGS];

  assign hit_status  = (addr == ADDR_STATUS);
  assign hit_enable  = (addr == ADDR_ENABLE);
  assign w1c         = (wr && hit_status) ? wdata[NUM_FLAGS-1:0] : '0;
  assign hw_set      = {tmo, chg};
  assign status_view = {tally, {(DATA_W-TALLY_W-NUM_FLAGS){1'b0}}, flags};
  assign enable_view = {{(DATA_W-NUM_FLAGS){1'b0}}, en};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      en    <= '0;
      tally <= '0;
      rdata <= '0;
      irq_n <= 1'b1;
    end else begin
      flags <= (flags & ~w1c) | hw_set;
      if (w1c[TMO_BIT])
        tally <= tmo ? TALLY_W'(1) : '0;
      else if (tmo && tally != TALLY_MAX)
        tally <= tally + 1'b1;
      if (wr && hit_enable)
        en <= wdata[NUM_FLAGS-1:0];
      if (hit_status)      rdata <= status_view;
      else if (hit_enable) rdata <= enable_view;
      else                 rdata <= '0;
      irq_n <= ~|(flags & en);
    end
  end
endmodule

// File: rtl/refclk_activity_mon.sv
module refclk_activity_mon
  import rcam_pkg::*;
#(
  parameter int WINDOW      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REF-1:0]  ref_in,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_n
);
  logic [NUM_REF-1:0]   line_s;
  logic [NUM_REF-1:0]   edges;
  logic [NUM_REF-1:0]   active;
  logic [NUM_REF-1:0]   chg;
  logic                 tmo_pulse;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] en;
  logic [TALLY_W-1:0]   tally;
  wire                  unused_active = ^active;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_line
    rcam_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (ref_in[i]),
      .q   (line_s[i])
    );
    rcam_activity #(.WINDOW(WINDOW)) u_act (
      .clk    (clk),
      .rst    (rst),
      .line_s (line_s[i]),
      .edge_o (edges[i]),
      .active (active[i]),
      .change (chg[i])
    );
  end

  rcam_idle_timer #(.WINDOW(WINDOW)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .any_edge (|edges),
    .fire     (tmo_pulse)
  );

  rcam_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .chg   (chg),
    .tmo   (tmo_pulse),
    .rdata (reg_rdata),
    .irq_n (irq_n),
    .flags (flags),
    .en    (en),
    .tally (tally)
  );
endmodule

// File: rtl/rcam_checker.sv
module rcam_checker
  import rcam_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] en,
  input logic [TALLY_W-1:0]   tally,
  input logic                 tmo,
  input logic [NUM_REF-1:0]   chg,
  input logic                 wr,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic                 irq_n
);
  logic clr_tmo;
  assign clr_tmo = wr && (addr == ADDR_STATUS) && wdata[TMO_BIT];

  assert_event0_R2: assert property (@(posedge clk) disable iff (rst)
    chg[0] |=> flags[0]);

  assert_event1_R3: assert property (@(posedge clk) disable iff (rst)
    chg[1] |=> flags[1]);

  assert_tally_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tmo && !clr_tmo) |=> $stable(tally));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tally == TALLY_MAX && !clr_tmo) |=> tally == TALLY_MAX);

  assert_zero_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_STATUS && wdata[NUM_FLAGS-1:0] == '0 && !tmo && chg == '0)
      |=> $stable(flags));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    !rdata[3]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    tmo |=> (flags[TMO_BIT] && tally != '0));

  assert_irq_level_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !(|($past(flags) & $past(en)))));
endmodule

bind refclk_activity_mon rcam_checker u_chk (
  .clk   (clk),
  .rst   (rst),
  .flags (flags),
  .en    (en),
  .tally (tally),
  .tmo   (tmo_pulse),
  .chg   (chg),
  .wr    (reg_wr),
  .addr  (reg_addr),
  .wdata (reg_wdata),
  .rdata (reg_rdata),
  .irq_n (irq_n)
);

// File: tb/sim_refclk_activity_mon.sv
module sim_refclk_activity_mon;
  localparam int W = 16;
  localparam logic [7:0] A_ST = 8'h22;
  localparam logic [7:0] A_EN = 8'h23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_in = 2'b00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_n;

  logic [1:0] tog_en = 2'b00;
  int         ph [2] = '{0, 0};
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  refclk_activity_mon #(.WINDOW(W)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n)
  );

  initial forever begin
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (tog_en[i]) begin
        ph[i] = ph[i] + 1;
        if (ph[i] >= 3) begin
          ph[i] = 0;
          ref_in[i] = ~ref_in[i];
        end
      end
    end
  end

  function automatic logic [7:0] exp_enable(input logic [7:0] w);
    return w & 8'h07;
  endfunction

  function automatic logic [7:0] exp_status(input logic [3:0] t, input logic [2:0] f);
    return {t, 1'b0, f};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] base;
    logic [7:0] wv;
    int hits;
    void'($urandom(32'h5eed_0042));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    do_rd(A_ST, rv); chk(rv == 8'h00, "R1 status", rv, 0);
    do_rd(A_EN, rv); chk(rv == 8'h00, "R1 enable", rv, 0);
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    // R12 unmapped offset
    do_rd(8'h40, rv); chk(rv == 8'h00, "R12 unmapped", rv, 0);

    // R2 line 0 starts toggling
    tog_en[0] = 1'b1;
    repeat (3*W) @(negedge clk);
    do_rd(A_ST, rv); chk(rv[0] == 1'b1, "R2 static->toggle", rv[0], 1);
    chk(rv[1] == 1'b0, "R3 no cross event", rv[1], 0);
    do_wr(A_ST, 8'h01);
    // R8 clear bit 2 resets tally
    do_wr(A_ST, 8'h04);
    do_rd(A_ST, rv); chk(rv == exp_status(4'd0, 3'b000), "R8 tally cleared", rv, exp_status(4'd0, 3'b000));
    repeat (3*W) @(negedge clk);
    do_rd(A_ST, rv);
    chk(rv[0] == 1'b0, "R4 steady toggling no event", rv[0], 0);
    chk(rv[7:4] == 4'd0 && rv[2] == 1'b0, "R5 no timeout while toggling", rv, 0);

    // R3 line 1 starts toggling
    tog_en[1] = 1'b1;
    repeat (3*W) @(negedge clk);
    do_rd(A_ST, rv); chk(rv == exp_status(4'd0, 3'b010), "R3 line1 event", rv, exp_status(4'd0, 3'b010));
    do_wr(A_ST, 8'h00);
    do_rd(A_ST, rv); chk(rv == exp_status(4'd0, 3'b010), "R7 zero write", rv, exp_status(4'd0, 3'b010));
    do_wr(A_ST, 8'h08);
    do_rd(A_ST, rv); chk(rv == exp_status(4'd0, 3'b010), "R9 reserved write", rv, exp_status(4'd0, 3'b010));
    do_wr(A_ST, 8'h03);
    do_rd(A_ST, rv); chk(rv == 8'h00, "R7 w1c", rv, 0);

    // R2 line 0 stops
    tog_en[0] = 1'b0;
    repeat (3*W) @(negedge clk);
    do_rd(A_ST, rv); chk(rv == exp_status(4'd0, 3'b001), "R2 toggle->static, R5 one active", rv, exp_status(4'd0, 3'b001));

    // R11 interrupt enables
    do_wr(A_EN, 8'h01); @(negedge clk);
    chk(irq_n == 1'b0, "R11 irq asserted", irq_n, 0);
    do_wr(A_EN, 8'h02); @(negedge clk);
    chk(irq_n == 1'b1, "R11 irq masked", irq_n, 1);
    do_wr(A_EN, 8'hFF);
    do_rd(A_EN, rv); chk(rv == 8'h07, "R11 enable readback", rv, 8'h07);
    for (int k = 0; k < 20; k++) begin
      wv = 8'($urandom);
      do_wr(A_EN, wv);
      do_rd(A_EN, rv); chk(rv == exp_enable(wv), "R11 random enable", rv, exp_enable(wv));
    end
    do_wr(A_EN, 8'h00);
    do_wr(A_ST, 8'h07);

    // R5 exact timeout count after both stop
    tog_en[1] = 1'b0;
    repeat (56) @(negedge clk);
    do_rd(A_ST, rv);
    chk(rv[7:4] == 4'd3 && rv[2] == 1'b1, "R5 timeout tally", rv[7:4], 3);

    // R6 saturation
    repeat (20*W) @(negedge clk);
    do_rd(A_ST, rv); chk(rv[7:4] == 4'd15, "R6 saturate", rv[7:4], 15);
    base = rv;
    for (int k = 0; k < 16; k++) begin
      wv = 8'($urandom) & 8'hF8;
      do_wr(A_ST, wv);
      do_rd(A_ST, rv); chk(rv == base, "R7 R9 random zero writes", rv, base);
    end

    // R10 clear swept across every timeout phase
    hits = 0;
    repeat ($urandom_range(0, W-1)) @(negedge clk);
    for (int k = 0; k < 2*W; k++) begin
      do_wr(A_ST, 8'h04);
      do_rd(A_ST, rv);
      chk(rv[7:4] == {3'b000, rv[2]}, "R10 tally matches flag", rv[7:4], rv[2]);
      if (rv[2]) hits++;
      repeat (W-1) @(negedge clk);
    end
    chk(hits >= 1, "R10 collision reached", hits, 1);

    finish_run();
  end
endmodule